// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes frames from a byte-wide stream and places each accepted frame into system memory. It does this through a ring of receive descriptors held in a shared descriptor RAM. A frame is taken only when the engine holds a ready descriptor. The frame's bytes are collected in a local buffer and checked against the station address, unless promiscuous mode is on. They are then written out as 32-bit words, starting at the buffer address that the descriptor's second word holds. Afterwards the descriptor's status word is rewritten with the frame length, READY cleared, and the length error flags.

The receive ring lives after the transmit descriptors in the same RAM. Its first index, and the index it returns to on a wrap, is twice the programmed transmit-descriptor count. Each descriptor takes two RAM words: a status word at the even index and a buffer pointer at the next index. Two event pulses report what happened: one for a stored frame and one for a frame that found no ready descriptor. These events feed one interrupt line through two mask inputs.

Top module: `rx_bd_engine`

## Requirements
- R1: After reset, and for as long as `rx_en` has been low since reset, the engine makes no memory write and no descriptor write, and it raises no event and no interrupt.
- R2: The first descriptor used is at index `2*tx_bd_count`. Each stored frame advances the index by 2. The index returns to `2*tx_bd_count` when the used status word has its WRAP bit (bit 13) set, or when the index is at `DESC_WORDS-2` or above.
- R3: The status word layout is: length in [31:16], READY bit 15, IRQ bit 14, WRAP bit 13, error flags in [6:0] (too-short bit 0, too-big bit 1). The write-back puts the frame length in [31:16], clears READY, clears all of [6:0] except the two length flags, and keeps bits [14:7] unchanged.
- R4: A frame that begins while the engine is enabled but the current descriptor is not ready produces a one-cycle `busy_event`. The frame is not stored.
- R5: With `promisc` low, a frame whose bytes 0..5 differ from `station_addr[47:40]`..`station_addr[7:0]` (byte 0 against the top byte) is discarded. The engine then waits for the next frame with the same descriptor. With `promisc` high, the address is not checked.
- R6: A frame shorter than 14 bytes is dropped without any write. Its descriptor stays in use for the next frame.
- R7: A stored frame is written as 32-bit words to `buffer + 4*k`, for k = 0, 1, ... The first byte of each group of four goes in bits [31:24]. Byte positions beyond the frame length in the last word are zero.
- R8: The too-short flag is set when length + 4 < `min_len`. The too-big flag is set when length > `max_len`.
- R9: `irq` pulses on a stored frame only when both `mask_rxb` and the descriptor's IRQ bit are set. It pulses on a busy event only when `mask_busy` is set.
- R10: `rxb_event` pulses for exactly one cycle per stored frame, in the same cycle as the descriptor write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks last byte of a frame |
| rx_en | input | 1 | Receive enable |
| promisc | input | 1 | Accept any destination address |
| min_len | input | 16 | Minimum frame length setting |
| max_len | input | 16 | Maximum frame length setting |
| tx_bd_count | input | IDXW-1 | Transmit descriptor count (ring base = 2x) |
| station_addr | input | 48 | Station address |
| mask_rxb | input | 1 | Interrupt mask for stored frames |
| mask_busy | input | 1 | Interrupt mask for busy events |
| bd_idx | output | IDXW | Descriptor RAM word index |
| bd_stat_rdata | input | 32 | RAM word at `bd_idx` |
| bd_buf_rdata | input | 32 | RAM word at `bd_idx+1` |
| bd_we | output | 1 | Status word write strobe |
| bd_wdata | output | 32 | Status word write data |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory word data |
| rxb_event | output | 1 | Frame stored pulse |
| busy_event | output | 1 | No-descriptor pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest case to reach is the return to the ring base through the WRAP bit. Only after it does the busy path fire, and this needs the descriptor that was just consumed to be seen as not ready. The stimulus fills three ready descriptors, with the WRAP bit on the third, and stores three frames. The fourth and fifth frames then arrive at the now-cleared first descriptor. Re-arming that descriptor while the engine polls, with stale error bits planted in it, then shows that those bits are cleared and the ring index came back to its base.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT_BD = 2'd1,
    ST_RECEIVE = 2'd2,
    ST_STORE   = 2'd3
  } rx_state_e;

  localparam int BIT_READY     = 15;
  localparam int BIT_IRQ       = 14;
  localparam int BIT_WRAP      = 13;
  localparam int BIT_TOO_BIG   = 1;
  localparam int BIT_TOO_SHORT = 0;
  localparam int HDR_BYTES     = 14;
  localparam int ADDR_BYTES    = 6;

  // Zero every lane of the word that lies at or beyond the frame length.
  function automatic logic [31:0] pack_word(input logic [31:0] raw,
                                            input logic [15:0] off,
                                            input logic [15:0] len);
    logic [31:0] w;
    w = raw;
    for (int l = 0; l < 4; l++) begin
      if ((17'(off) + 17'(l)) >= 17'(len)) w[31-8*l -: 8] = 8'h00;
    end
    return w;
  endfunction

  // {too_big, too_short}
  function automatic logic [1:0] length_flags(input logic [15:0] len,
                                              input logic [15:0] min_l,
                                              input logic [15:0] max_l);
    logic short_f, big_f;
    short_f = (17'(len) + 17'd4) < 17'(min_l);
    big_f   = len > max_l;
    return {big_f, short_f};
  endfunction

  function automatic logic [31:0] status_out(input logic [31:0] stat,
                                             input logic [15:0] len,
                                             input logic [1:0]  flags);
    logic [31:0] s;
    s = stat;
    s[31:16]     = len;
    s[BIT_READY] = 1'b0;
    s[6:0]       = 7'b0;
    s[1:0]       = flags;
    return s;
  endfunction

endpackage

// File: rtl/rxbd_addr_filter.sv
module rxbd_addr_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_en,
  input  logic [15:0] pos,
  input  logic [7:0]  data,
  input  logic [47:0] station,
  output logic        match
);
  import rxbd_pkg::*;

  logic [7:0] ref_b;

  always_comb begin
    case (pos[2:0])
      3'd0:    ref_b = station[47:40];
      3'd1:    ref_b = station[39:32];
      3'd2:    ref_b = station[31:24];
      3'd3:    ref_b = station[23:16];
      3'd4:    ref_b = station[15:8];
      default: ref_b = station[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match <= 1'b0;
    end else if (byte_en && pos < 16'(ADDR_BYTES)) begin
      if (pos == 16'd0) match <= (data == ref_b);
      else              match <= match && (data == ref_b);
    end
  end

endmodule

// File: rtl/rxbd_frame_buf.sv
module rxbd_frame_buf #(
  parameter int BUF_BYTES = 128
) (
  input  logic        clk,
  input  logic        we,
  input  logic [15:0] waddr,
  input  logic [7:0]  wdata,
  input  logic [15:0] rd_off,
  output logic [31:0] rd_word
);
  localparam int BW = $clog2(BUF_BYTES);

  logic [7:0] mem [BUF_BYTES];

  always_ff @(posedge clk) begin
    if (we && (waddr < 16'(BUF_BYTES))) mem[waddr[BW-1:0]] <= wdata;
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [16:0] pos;
    assign pos = 17'(rd_off) + 17'(l);
    assign rd_word[31-8*l -: 8] = (pos < 17'(BUF_BYTES)) ? mem[pos[BW-1:0]] : 8'h00;
  end

endmodule

// File: rtl/rxbd_ring.sv
module rxbd_ring #(
  parameter int DESC_WORDS = 256,
  localparam int IDXW = $clog2(DESC_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            advance,
  input  logic            wrap_req,
  input  logic [IDXW-2:0] base_cnt,
  output logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DESC_WORDS - 2);

  logic            primed;
  logic [IDXW-1:0] base;

  assign base = {base_cnt, 1'b0};

  function automatic logic [IDXW-1:0] next_index(input logic [IDXW-1:0] cur,
                                                 input logic wrap,
                                                 input logic [IDXW-1:0] b);
    if (wrap || cur >= LAST_IDX) return b;
    return cur + IDXW'(2);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      idx    <= '0;
    end else if (arm && !primed) begin
      primed <= 1'b1;
      idx    <= base;
    end else if (advance) begin
      idx    <= next_index(idx, wrap_req, base);
    end
  end

endmodule

// File: rtl/rx_bd_engine.sv
module rx_bd_engine #(
  parameter int DESC_WORDS = 256,
  parameter int BUF_BYTES  = 128,
  localparam int IDXW = $clog2(DESC_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  input  logic            rx_last,
  input  logic            rx_en,
  input  logic            promisc,
  input  logic [15:0]     min_len,
  input  logic [15:0]     max_len,
  input  logic [IDXW-2:0] tx_bd_count,
  input  logic [47:0]     station_addr,
  input  logic            mask_rxb,
  input  logic            mask_busy,
  output logic [IDXW-1:0] bd_idx,
  input  logic [31:0]     bd_stat_rdata,
  input  logic [31:0]     bd_buf_rdata,
  output logic            bd_we,
  output logic [31:0]     bd_wdata,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  output logic            rxb_event,
  output logic            busy_event,
  output logic            irq
);
  import rxbd_pkg::*;

  rx_state_e   state_q, state_d;
  logic        in_frame_q, capturing_q;
  logic [15:0] byte_cnt_q, fr_len_q, off_q;
  logic [31:0] stat_q, buf_base_q;

  // named internal events
  logic        frame_start, cap_byte, frame_end, frame_short, frame_accept;
  logic        addr_ok, desc_ready, store_active, store_last, ring_adv, desc_irq_en;
  logic [15:0] cap_pos, len_now, stored_len;
  logic [31:0] raw_word;

  assign frame_start  = rx_valid && !in_frame_q;
  assign cap_byte     = (state_q == ST_RECEIVE) && rx_valid && (capturing_q || frame_start);
  assign cap_pos      = frame_start ? 16'd0 : byte_cnt_q;
  assign len_now      = cap_pos + 16'd1;
  assign frame_end    = cap_byte && rx_last;
  assign frame_short  = frame_end && (len_now < 16'(HDR_BYTES));
  assign frame_accept = frame_end && !frame_short && (promisc || addr_ok);
  assign desc_ready   = bd_stat_rdata[BIT_READY];
  assign store_active = (state_q == ST_STORE);
  assign stored_len   = (fr_len_q > 16'(BUF_BYTES)) ? 16'(BUF_BYTES) : fr_len_q;
  assign store_last   = store_active && ((17'(off_q) + 17'd4) >= 17'(stored_len));
  assign desc_irq_en  = stat_q[BIT_IRQ];

  rxbd_addr_filter u_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_en (cap_byte),
    .pos     (cap_pos),
    .data    (rx_data),
    .station (station_addr),
    .match   (addr_ok)
  );

  rxbd_frame_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk     (clk),
    .we      (cap_byte),
    .waddr   (cap_pos),
    .wdata   (rx_data),
    .rd_off  (off_q),
    .rd_word (raw_word)
  );

  rxbd_ring #(.DESC_WORDS(DESC_WORDS)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm      ((state_q == ST_IDLE) && rx_en),
    .advance  (ring_adv),
    .wrap_req (stat_q[BIT_WRAP]),
    .base_cnt (tx_bd_count),
    .idx      (bd_idx)
  );

  always_comb begin
    state_d    = state_q;
    mem_we     = 1'b0;
    bd_we      = 1'b0;
    rxb_event  = 1'b0;
    busy_event = 1'b0;
    ring_adv   = 1'b0;
    case (state_q)
      ST_IDLE:    if (rx_en) state_d = ST_WAIT_BD;
      ST_WAIT_BD: begin
        if (desc_ready)       state_d = ST_RECEIVE;
        else if (!rx_en)      state_d = ST_IDLE;
        else if (frame_start) busy_event = 1'b1;
      end
      ST_RECEIVE: begin
        if (frame_short)       state_d = ST_IDLE;
        else if (frame_accept) state_d = ST_STORE;
      end
      ST_STORE: begin
        mem_we = 1'b1;
        if (store_last) begin
          bd_we     = 1'b1;
          rxb_event = 1'b1;
          ring_adv  = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign mem_addr  = buf_base_q + 32'(off_q);
  assign mem_wdata = pack_word(raw_word, off_q, fr_len_q);
  assign bd_wdata  = status_out(stat_q, fr_len_q, length_flags(fr_len_q, min_len, max_len));
  assign irq       = (rxb_event && mask_rxb && desc_irq_en) || (busy_event && mask_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      in_frame_q  <= 1'b0;
      capturing_q <= 1'b0;
      byte_cnt_q  <= '0;
      fr_len_q    <= '0;
      off_q       <= '0;
      stat_q      <= '0;
      buf_base_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rx_valid) in_frame_q <= !rx_last;
      if (state_q != ST_RECEIVE) capturing_q <= 1'b0;
      else if (cap_byte)         capturing_q <= !rx_last;
      if (cap_byte) byte_cnt_q <= len_now;
      if (frame_accept) begin
        fr_len_q <= len_now;
        off_q    <= '0;
      end else if (store_active) begin
        off_q    <= off_q + 16'd4;
      end
      if (state_q == ST_WAIT_BD && desc_ready) begin
        stat_q     <= {bd_stat_rdata[31:7], 7'b0};
        buf_base_q <= bd_buf_rdata;
      end
    end
  end

endmodule

// File: rtl/rxbd_checker.sv
module rxbd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        bd_we,
  input logic [31:0] bd_wdata,
  input logic [31:0] bd_stat_rdata,
  input logic        rxb_event,
  input logic        busy_event,
  input logic        irq,
  input logic        mask_rxb,
  input logic        mask_busy,
  input logic        store_active,
  input logic        desc_irq_en,
  input logic        frame_short
);
  import rxbd_pkg::*;

  a_r7_write_in_store: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> store_active);

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 32'd4));

  a_r3_ready_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    bd_we |-> !bd_wdata[BIT_READY]);

  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    busy_event |-> !bd_stat_rdata[BIT_READY]);

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((rxb_event && mask_rxb && desc_irq_en) || (busy_event && mask_busy)));

  a_r10_rxb_with_desc: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_event |-> (bd_we && mem_we));

  a_r10_rxb_single: assert property (@(posedge clk) disable iff (!rst_n)
    rxb_event |=> !rxb_event);

  a_r6_short_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    frame_short |=> !mem_we);

endmodule

bind rx_bd_engine rxbd_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .bd_we         (bd_we),
  .bd_wdata      (bd_wdata),
  .bd_stat_rdata (bd_stat_rdata),
  .rxb_event     (rxb_event),
  .busy_event    (busy_event),
  .irq           (irq),
  .mask_rxb      (mask_rxb),
  .mask_busy     (mask_busy),
  .store_active  (store_active),
  .desc_irq_en   (desc_irq_en),
  .frame_short   (frame_short)
);

// File: tb/rx_bd_engine_tb_top.sv
`timescale 1ns/1ps
module rx_bd_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_en = 1'b0, promisc = 1'b0;
  logic [15:0] min_len = 16'd64, max_len = 16'd1536;
  logic [6:0]  tx_bd_count = 7'd10;
  logic [47:0] station_addr = 48'h02_11_22_33_44_55;
  logic        mask_rxb = 1'b1, mask_busy = 1'b1;
  logic [7:0]  bd_idx;
  logic [31:0] bd_stat_rdata, bd_buf_rdata, bd_wdata, mem_addr, mem_wdata;
  logic        bd_we, mem_we, rxb_event, busy_event, irq;

  always #2.5 clk = ~clk;

  rx_bd_engine dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_en(rx_en), .promisc(promisc), .min_len(min_len), .max_len(max_len),
    .tx_bd_count(tx_bd_count), .station_addr(station_addr), .mask_rxb(mask_rxb),
    .mask_busy(mask_busy), .bd_idx(bd_idx), .bd_stat_rdata(bd_stat_rdata),
    .bd_buf_rdata(bd_buf_rdata), .bd_we(bd_we), .bd_wdata(bd_wdata), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rxb_event(rxb_event),
    .busy_event(busy_event), .irq(irq)
  );

  logic [31:0] dram [256];
  assign bd_stat_rdata = dram[bd_idx];
  assign bd_buf_rdata  = dram[bd_idx + 8'd1];
  always @(posedge clk) if (bd_we) dram[bd_idx] <= bd_wdata;

  logic [63:0] exp_mem_q [$];
  logic [39:0] exp_bd_q [$];
  logic [7:0]  fbytes [$];
  int checks = 0, fails = 0;
  int n_rxb = 0, n_busy = 0, n_irq = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes and counts event pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (exp_mem_q.size() == 0) check(1'b0, "R7 unexpected write", {mem_addr, mem_wdata}, 64'h0);
        else begin
          logic [63:0] e;
          e = exp_mem_q.pop_front();
          check({mem_addr, mem_wdata} == e, "R7 word write", {mem_addr, mem_wdata}, e);
        end
      end
      if (bd_we) begin
        if (exp_bd_q.size() == 0) check(1'b0, "R3 unexpected descriptor write", {24'h0, bd_idx, bd_wdata}, 64'h0);
        else begin
          logic [39:0] e;
          e = exp_bd_q.pop_front();
          check({bd_idx, bd_wdata} == e, "R2/R3/R8 descriptor write", {24'h0, bd_idx, bd_wdata}, {24'h0, e});
        end
      end
      if (rxb_event)  n_rxb++;
      if (busy_event) n_busy++;
      if (irq)        n_irq++;
    end
  end

  task automatic build_frame(input bit match, input int len, input int seed);
    fbytes.delete();
    for (int i = 0; i < len; i++) begin
      if (i < 6) fbytes.push_back(match ? station_addr[8*(5-i) +: 8] : (8'hE0 ^ 8'(i)));
      else       fbytes.push_back(8'(i * 7 + seed));
    end
  endtask

  task automatic send_frame();
    for (int i = 0; i < fbytes.size(); i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbytes[i];
      rx_last  = (i == fbytes.size() - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic expect_store(input logic [31:0] buf_a, input logic [7:0] idx, input logic [31:0] stat);
    int len;
    logic [31:0] s;
    len = fbytes.size();
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] word;
      word = 32'h0;
      for (int l = 0; l < 4; l++)
        if (4 * w + l < len) word[31-8*l -: 8] = fbytes[4*w+l];
      exp_mem_q.push_back({buf_a + 32'(4 * w), word});
    end
    s = (stat & 32'h0000_7F80) | {16'(len), 16'h0};
    if (len + 4 < int'(min_len)) s[0] = 1'b1;
    if (len > int'(max_len))     s[1] = 1'b1;
    exp_bd_q.push_back({idx, s});
  endtask

  task automatic check_counts(input string req, input int rxb, input int busy, input int irqs);
    check(n_rxb == rxb, {req, " rxb_event count"}, 64'(n_rxb), 64'(rxb));
    check(n_busy == busy, {req, " busy_event count"}, 64'(n_busy), 64'(busy));
    check(n_irq == irqs, {req, " irq count"}, 64'(n_irq), 64'(irqs));
    check(exp_mem_q.size() == 0 && exp_bd_q.size() == 0, {req, " pending expected writes"},
          64'(exp_mem_q.size() + exp_bd_q.size()), 64'h0);
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) dram[i] = 32'h0;
    dram[20] = 32'h0000_C000; dram[21] = 32'h0000_1000;
    dram[22] = 32'h0000_8000; dram[23] = 32'h0000_2000;
    dram[24] = 32'h0000_E000; dram[25] = 32'h0000_3000;
    gap(3);
    rst_n = 1'b1;
    gap(1);
    // R1: reset state
    check(!mem_we && !bd_we && !irq && !rxb_event && !busy_event, "R1 reset outputs",
          {59'h0, mem_we, bd_we, irq, rxb_event, busy_event}, 64'h0);
    // R1: disabled, a good frame is ignored
    build_frame(1'b1, 20, 1); send_frame(); gap(40);
    check_counts("R1", 0, 0, 0);

    rx_en = 1'b1; gap(6);
    // R6: 13-byte frame dropped
    build_frame(1'b1, 13, 2); send_frame(); gap(10);
    check_counts("R6", 0, 0, 0);
    // R5: wrong address discarded
    build_frame(1'b0, 20, 3); send_frame(); gap(10);
    check_counts("R5", 0, 0, 0);
    // R7 R8 R9: 18-byte frame, too short, irq
    build_frame(1'b1, 18, 4); expect_store(32'h1000, 8'd20, 32'h0000_C000);
    send_frame(); gap(40);
    check_counts("R7", 1, 0, 1);
    // R8: too big as well; R9 no irq without descriptor IRQ bit
    max_len = 16'd20;
    build_frame(1'b1, 22, 5); expect_store(32'h2000, 8'd22, 32'h0000_8000);
    send_frame(); gap(40);
    check_counts("R8", 2, 0, 1);
    // R5 promiscuous; R2 wrap flag
    min_len = 16'd16; promisc = 1'b1;
    build_frame(1'b0, 15, 6); expect_store(32'h3000, 8'd24, 32'h0000_E000);
    send_frame(); gap(40); promisc = 1'b0;
    check_counts("R5", 3, 0, 2);
    // R4: ring back at 20, descriptor no longer ready
    build_frame(1'b1, 16, 7); send_frame(); gap(10);
    check_counts("R4", 3, 1, 3);
    mask_busy = 1'b0;
    build_frame(1'b1, 16, 8); send_frame(); gap(10);
    check_counts("R9", 3, 2, 3);
    // R3 R2: re-arm index 20 with stale error bits; mask off
    mask_rxb = 1'b0;
    dram[21] = 32'h0000_4000;
    dram[20] = 32'h0000_C27F;
    gap(6);
    build_frame(1'b1, 16, 9); expect_store(32'h4000, 8'd20, 32'h0000_C27F);
    send_frame(); gap(40);
    check_counts("R3", 4, 2, 3);
    check(!mem_we && !bd_we, "R10 idle after store", {62'h0, mem_we, bd_we}, 64'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule